// File: doc/BRIEF.md
# Reset Cause Unit with Stuck-Clock Watchdog

This block merges the reset causes of a small processor subsystem into one system reset and keeps a record of which causes started the most recent reset. The causes are an active-low external reset pin, a supply-monitor condition, and a detector that watches the system clock and fires when that clock stops toggling. The detector runs from an independent free-running reference clock. The whole block, including its register port, lives in that reference domain and is cleared only by its own power-on reset.

A register port with two addresses gives software control. The supply-monitor control register holds the monitor enable and shows live status. The cause register holds the captured flags and takes two settings: the enable for the stuck-clock detector and the selection of the supply monitor as a reset source. While the low-power input is high, the detector is held off. Its stored enable is left untouched, so the detector resumes on wake without a rewrite.

The system reset stays asserted for a fixed number of reference cycles after the last cause goes away. It is released on a reference-clock edge.

Top module: `reset_cause_unit`

## Requirements
- R1: A low level on `ext_rst_n` asserts `sys_rst_n` low within 4 reference cycles. This holds whether `low_power` is 0 or 1.
- R2: After a reset caused only by the pin, bit 0 of the cause register (`reg_sel`=1) reads 1.
- R3: When the detector is enabled and `mon_clk` makes no edge for `TIMEOUT_CYC` reference cycles, a reset is asserted. A toggling `mon_clk` never causes one.
- R4: Bit 2 of the cause register reads 1 after a stuck-clock reset and reads 0 after a reset with any other cause. Writing bit 2 of the cause register sets the detector enable (1 = on, 0 = off). The enable is 1 after power-on.
- R5: While `low_power` is 1 the detector cannot fire. When `low_power` returns to 0, the enable stored before entry applies again.
- R6: Control register (`reg_sel`=0) layout: bit 7 is the supply-monitor enable (read/write). Bit 6 is the synchronised `supply_ok`. Bit 5 is the synchronised `supply_warn_ok`. Bits 4:0 read 0 whatever is written.
- R7: The supply monitor causes a reset only when `supply_ok` is 0, control bit 7 is 1, and cause-register bit 1 has been written to 1. After such a reset, cause bit 1 reads 1.
- R8: `sys_rst_n` stays low for `HOLD_CYC` reference cycles after every cause has cleared, then rises. It is also low during and after power-on reset.
- R9: Causes active in the same cycle all set their flags. The flags keep their value until the next reset event replaces them.
- R10: Register writes never change the flags. Bit 0 of a cause-register write is ignored, and cause-register bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked here |
| por_n | input | 1 | Power-on reset for the block itself, synchronous, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mon_clk | input | 1 | System clock under watch, asynchronous |
| supply_ok | input | 1 | Supply above reset threshold, asynchronous |
| supply_warn_ok | input | 1 | Supply above early-warning threshold, asynchronous |
| low_power | input | 1 | Suspend/sleep indication, reference-domain |
| reg_sel | input | 1 | 0 = control register, 1 = cause register |
| reg_wr | input | 1 | Write strobe for one reference cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sys_rst_n | output | 1 | System reset, active low |
| cause_flags | output | 3 | Captured flags: bit 0 pin, bit 1 supply, bit 2 stuck clock |

## Verification
Errors in the detector's edge counter or in its gated enable show up at `sys_rst_n`. A stuck-clock reset either goes missing or fires while the clock still toggles, and the error becomes visible within roughly `TIMEOUT_CYC` plus five reference cycles. A corrupted flag capture is visible at the next register read after the reset releases, and it stays visible until the next reset event. A wrong hold counter changes how many cycles pass before `sys_rst_n` rises, so the bench samples on both sides of the expected release edge.

// File: rtl/rcu_pkg.sv
// Package: shared constants and types for the reset cause unit.
// Assumes an 8-bit register port with two addresses.
package rcu_pkg;
    localparam int REG_W     = 8;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_SRC  = 1'b1;

    // Control register bit positions
    localparam int CTRL_EN_B   = 7;
    localparam int CTRL_OK_B   = 6;
    localparam int CTRL_WARN_B = 5;

    // Cause register bit positions (field order fixed by software)
    localparam int SRC_PIN_B = 0;
    localparam int SRC_SUP_B = 1;
    localparam int SRC_MCD_B = 2;
    localparam int NCAUSE    = 3;

    typedef struct packed {
        logic mcd;
        logic sup;
        logic pin;
    } cause_t;
endpackage

// File: rtl/rcu_sync.sv
// Module: rcu_sync
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a level or a slow toggle; no bus coherence is implied.
module rcu_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rcu_clk_watch.sv
// Module: rcu_clk_watch
// Stuck-clock detector. Counts reference cycles since the last edge of the
// synchronised watched clock and raises fire once TIMEOUT_CYC is reached.
// Assumes the watched clock is already synchronised; en gates everything.
module rcu_clk_watch #(
    parameter int TIMEOUT_CYC = 20000
) (
    input  logic ref_clk,
    input  logic por_n,
    input  logic en,
    input  logic mon_s,
    output logic fire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             mon_prev;
    logic [CNT_W-1:0] cnt;
    logic             edge_seen;

    assign edge_seen = mon_s ^ mon_prev;
    assign fire      = (cnt == CNT_W'(TIMEOUT_CYC));

    // Remember the previous synchronised level for edge detection
    always_ff @(posedge ref_clk) begin
        if (!por_n) mon_prev <= 1'b0;
        else        mon_prev <= mon_s;
    end

    // Saturating idle counter, cleared on any edge or while disabled
    always_ff @(posedge ref_clk) begin
        if (!por_n)                  cnt <= '0;
        else if (!en || edge_seen)   cnt <= '0;
        else if (!fire)              cnt <= cnt + 1'b1;
    end

    assert_edge_clears_R3: assert property (@(posedge ref_clk) disable iff (!por_n)
        (en && edge_seen) |=> !fire);
    assert_off_silent_R5: assert property (@(posedge ref_clk) disable iff (!por_n)
        !en |=> !fire);
endmodule

// File: rtl/rcu_rst_seq.sv
// Module: rcu_rst_seq
// Reset sequencer: asserts reset while any cause is active, stretches it by
// HOLD_CYC reference cycles, and captures the cause flags per reset event.
// Assumes causes are reference-domain levels; HOLD_CYC >= 1.
module rcu_rst_seq
    import rcu_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic              ref_clk,
    input  logic              por_n,
    input  cause_t            cause,
    output logic              sys_rst_n,
    output logic [NCAUSE-1:0] flags
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic              in_rst;
    logic [HOLD_W-1:0] hold;
    logic              any_cause;

    assign any_cause = |cause;
    assign sys_rst_n = ~in_rst;

    // Assert on cause, count down the stretch, then release on an edge
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            in_rst <= 1'b1;
            hold   <= HOLD_W'(HOLD_CYC);
        end else if (any_cause) begin
            in_rst <= 1'b1;
            hold   <= HOLD_W'(HOLD_CYC);
        end else if (hold != '0) begin
            hold   <= hold - 1'b1;
        end else begin
            in_rst <= 1'b0;
        end
    end

    // Fresh capture at event start, accumulate while the event lasts
    always_ff @(posedge ref_clk) begin
        if (!por_n)                      flags <= '0;
        else if (any_cause && !in_rst)   flags <= cause;
        else if (any_cause)              flags <= flags | cause;
    end

    assert_cause_holds_R1: assert property (@(posedge ref_clk) disable iff (!por_n)
        any_cause |=> !sys_rst_n);
    assert_release_quiet_R8: assert property (@(posedge ref_clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> $past(!any_cause));
    assert_fresh_flags_R9: assert property (@(posedge ref_clk) disable iff (!por_n)
        (any_cause && !in_rst) |=> (flags == $past(cause)));
    assert_flags_steady_R9: assert property (@(posedge ref_clk) disable iff (!por_n)
        !any_cause |=> $stable(flags));
endmodule

// File: rtl/rcu_regs.sv
// Module: rcu_regs
// Register port: supply-monitor control and cause/enable register.
// Assumes single-cycle write strobes in the reference domain; reads are
// combinational from the selected register.
module rcu_regs
    import rcu_pkg::*;
(
    input  logic              ref_clk,
    input  logic              por_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ok_s,
    input  logic              warn_s,
    input  logic [NCAUSE-1:0] flags,
    output logic              mon_en,
    output logic              sup_sel,
    output logic              mcd_en
);
    logic wr_ctrl, wr_src;

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_src  = reg_wr && (reg_sel == SEL_SRC);

    // Supply-monitor enable: only bit 7 of the control register is stored
    always_ff @(posedge ref_clk) begin
        if (!por_n)       mon_en <= 1'b0;
        else if (wr_ctrl) mon_en <= reg_wdata[CTRL_EN_B];
    end

    // Detector enable and supply source select from the cause register
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            mcd_en  <= 1'b1;
            sup_sel <= 1'b0;
        end else if (wr_src) begin
            mcd_en  <= reg_wdata[SRC_MCD_B];
            sup_sel <= reg_wdata[SRC_SUP_B];
        end
    end

    // Read mux: status bits live, reserved bits zero
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[CTRL_EN_B]   = mon_en;
            reg_rdata[CTRL_OK_B]   = ok_s;
            reg_rdata[CTRL_WARN_B] = warn_s;
        end else begin
            reg_rdata[NCAUSE-1:0]  = flags;
        end
    end

    assert_mon_en_write_R6: assert property (@(posedge ref_clk) disable iff (!por_n)
        wr_ctrl |=> (mon_en == $past(reg_wdata[CTRL_EN_B])));
    assert_mcd_en_write_R4: assert property (@(posedge ref_clk) disable iff (!por_n)
        wr_src |=> (mcd_en == $past(reg_wdata[SRC_MCD_B])));
endmodule

// File: rtl/reset_cause_unit.sv
// Module: reset_cause_unit (top)
// Merges pin, supply-monitor and stuck-clock causes into one system reset,
// records the causes, and exposes a two-register control port.
// Assumes por_n, low_power and the register port are synchronous to ref_clk;
// ext_rst_n, mon_clk and the supply status inputs are asynchronous.
module reset_cause_unit
    import rcu_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20000,
    parameter int HOLD_CYC    = 16
) (
    input  logic              ref_clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              mon_clk,
    input  logic              supply_ok,
    input  logic              supply_warn_ok,
    input  logic              low_power,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sys_rst_n,
    output logic [NCAUSE-1:0] cause_flags
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw, syn;
    logic             mon_en, sup_sel, mcd_en, mcd_fire;
    cause_t           cause;

    assign raw = {supply_warn_ok, supply_ok, mon_clk, ext_rst_n};

    rcu_sync #(.W(NSYNC), .RST_VAL(4'b1101)) u_sync (
        .clk(ref_clk), .rst_n(por_n), .d(raw), .q(syn)
    );

    rcu_clk_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .ref_clk(ref_clk), .por_n(por_n),
        .en(mcd_en && !low_power), .mon_s(syn[1]), .fire(mcd_fire)
    );

    assign cause.pin = ~syn[0];
    assign cause.sup = mon_en & sup_sel & ~syn[2];
    assign cause.mcd = mcd_fire;

    rcu_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .ref_clk(ref_clk), .por_n(por_n), .cause(cause),
        .sys_rst_n(sys_rst_n), .flags(cause_flags)
    );

    rcu_regs u_regs (
        .ref_clk(ref_clk), .por_n(por_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ok_s(syn[2]), .warn_s(syn[3]),
        .flags(cause_flags), .mon_en(mon_en), .sup_sel(sup_sel),
        .mcd_en(mcd_en)
    );

    assert_pin_reset_R1: assert property (@(posedge ref_clk) disable iff (!por_n)
        !syn[0] |=> !sys_rst_n);
    assert_sup_gated_R7: assert property (@(posedge ref_clk) disable iff (!por_n)
        (sys_rst_n && !mon_en && syn[0] && !mcd_fire) |=> !cause_flags[SRC_SUP_B] || $stable(cause_flags));
endmodule

// File: tb/sim_reset_cause_unit.sv
module sim_reset_cause_unit;
    localparam int TO   = 40;
    localparam int HOLD = 4;

    logic       ref_clk = 1'b0;
    logic       por_n = 1'b0, ext_rst_n = 1'b1, mon_clk = 1'b0;
    logic       supply_ok = 1'b1, supply_warn_ok = 1'b1, low_power = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_rst_n;
    logic [2:0] cause_flags;
    logic       mon_run = 1'b1;
    int         checks = 0, errors = 0;

    always #2.5 ref_clk = ~ref_clk;
    always #15 if (mon_run) mon_clk = ~mon_clk;

    reset_cause_unit #(.TIMEOUT_CYC(TO), .HOLD_CYC(HOLD)) u0 (
        .ref_clk(ref_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .mon_clk(mon_clk), .supply_ok(supply_ok), .supply_warn_ok(supply_warn_ok),
        .low_power(low_power), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst_n(sys_rst_n), .cause_flags(cause_flags)
    );

    // {write data to control register, expected read-back} for R6
    localparam logic [15:0] VEC [6] = '{
        {8'h80, 8'hE0}, {8'h00, 8'h60}, {8'hFF, 8'hE0},
        {8'h1F, 8'h60}, {8'h9C, 8'hE0}, {8'h00, 8'h60}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge ref_clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge ref_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input string req, input logic [7:0] exp);
        reg_sel = sel;
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        cyc(5);
        check("R8 por", {7'd0, sys_rst_n}, 8'h00);
        por_n = 1'b1;
        cyc(2);
        check("R8 stretch", {7'd0, sys_rst_n}, 8'h00);
        cyc(HOLD + 4);
        check("R8 released", {7'd0, sys_rst_n}, 8'h01);
        rd(1'b1, "R9 flags after por", 8'h00);

        foreach (VEC[i]) begin
            wr(1'b0, VEC[i][15:8]);
            rd(1'b0, "R6 ctrl readback", VEC[i][7:0]);
        end

        // Pin reset and stretch length
        ext_rst_n = 1'b0;
        cyc(5);
        check("R1 pin", {7'd0, sys_rst_n}, 8'h00);
        ext_rst_n = 1'b1;
        cyc(5);
        check("R8 still held", {7'd0, sys_rst_n}, 8'h00);
        cyc(HOLD);
        check("R8 release", {7'd0, sys_rst_n}, 8'h01);
        rd(1'b1, "R2 pin flag", 8'h01);

        // Stuck clock with detector enabled (default)
        mon_run = 1'b0;
        cyc(TO + 20);
        check("R3 stuck clock", {7'd0, sys_rst_n}, 8'h00);
        mon_run = 1'b1;
        cyc(30);
        check("R3 recover", {7'd0, sys_rst_n}, 8'h01);
        rd(1'b1, "R4 mcd flag", 8'h04);

        // A pin reset clears the stuck-clock flag
        ext_rst_n = 1'b0; cyc(6); ext_rst_n = 1'b1; cyc(HOLD + 8);
        rd(1'b1, "R4 other reset", 8'h01);

        // Detector disabled
        wr(1'b1, 8'h00);
        mon_run = 1'b0; cyc(3 * TO);
        check("R4 disabled", {7'd0, sys_rst_n}, 8'h01);
        mon_run = 1'b1; cyc(10);
        wr(1'b1, 8'h04);

        // Low power gating, pin still works, enable restored on wake
        low_power = 1'b1;
        mon_run = 1'b0; cyc(3 * TO);
        check("R5 low power", {7'd0, sys_rst_n}, 8'h01);
        ext_rst_n = 1'b0; cyc(5);
        check("R1 pin in low power", {7'd0, sys_rst_n}, 8'h00);
        ext_rst_n = 1'b1; cyc(HOLD + 8);
        check("R5 no mcd while low", {7'd0, sys_rst_n}, 8'h01);
        low_power = 1'b0;
        cyc(TO + 20);
        check("R5 restored", {7'd0, sys_rst_n}, 8'h00);
        mon_run = 1'b1; cyc(30);
        rd(1'b1, "R5 mcd flag after wake", 8'h04);

        // Supply monitor: enabled but not selected
        wr(1'b0, 8'h80);
        supply_ok = 1'b0; cyc(20);
        check("R7 not selected", {7'd0, sys_rst_n}, 8'h01);
        supply_ok = 1'b1; cyc(5);
        wr(1'b1, 8'h06);
        supply_ok = 1'b0; cyc(6);
        check("R7 supply reset", {7'd0, sys_rst_n}, 8'h00);
        rd(1'b0, "R6 live ok low", 8'hA0);
        supply_ok = 1'b1; cyc(HOLD + 8);
        rd(1'b1, "R7 supply flag", 8'h02);

        // Two causes together
        ext_rst_n = 1'b0; supply_ok = 1'b0; cyc(6);
        ext_rst_n = 1'b1; supply_ok = 1'b1; cyc(HOLD + 8);
        rd(1'b1, "R9 both flags", 8'h03);
        cyc(20);
        rd(1'b1, "R9 flags persist", 8'h03);

        // Writes leave flags alone, bit 0 ignored, high bits read 0
        wr(1'b1, 8'hFF);
        rd(1'b1, "R10 write ignored", 8'h03);
        check("R10 flag port", {5'd0, cause_flags}, 8'h03);
        wr(1'b1, 8'h04);

        finish_run();
    end
endmodule